// File: doc/BRIEF.md
# Task Wakeup Timer

This block simulates a periodic device that needs service from one fixed task. A load strobe writes a data word. The upper field of that word is a period expressed in prescaler units, and the low `PRE_SHIFT` bits are ignored. A non-zero period arms the timer and restarts its count at once. A zero period stops it.

When the count expires, the block raises a wakeup request to the task scheduler. The request always names the same target task. The scheduler acknowledges the request when it starts running that task, and the request then drops. The task does its work and blocks. The counter reloads on every expiry, so requests repeat with a fixed period until a zero period is written.

A test program uses the block to prove that a task can be woken by hardware within a known number of cycles. It also uses the block to stop that wakeup source when the test is done.

Top module: `task_wake_timer`

## Requirements
- R1: After reset the stored period is zero, so `wakeReq` is low and stays low until a non-zero period is loaded.
- R2: `wakeTask` always carries the parameter `TARGET_TASK` (default 10, octal 12).
- R3: A load takes its period as `loadData[DATA_W-1:PRE_SHIFT]` and ignores the low `PRE_SHIFT` bits. A load whose period field is zero disables the timer, even when the ignored low bits are not zero.
- R4: After a load of period N > 0 on clock edge E, `wakeReq` is first high after edge E + N·2^PRE_SHIFT and is low before that edge.
- R5: The timer reloads itself on every expiry, so later expiries follow every N·2^PRE_SHIFT edges.
- R6: `wakeReq` stays high until an edge samples `ackValid` high with `ackTask` equal to the target. An acknowledge that names any other task has no effect.
- R7: A matching acknowledge clears `wakeReq` at the edge that samples it. If an expiry falls on that same edge, `wakeReq` stays high.
- R8: A zero load clears a pending request at the edge that samples it. No request is raised after that until the next non-zero load.
- R9: A non-zero load while the timer is counting discards the count in progress and starts timing the new period from the load edge.
- R10: With the default `PRE_SHIFT` of 8, a load of 400 octal gives the shortest period, 256 cycles. Any load below 400 octal disables the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load strobe for the period word |
| loadData | input | DATA_W | Period word; the upper field is the period, zero stops the timer |
| ackValid | input | 1 | Scheduler is acknowledging a task as running |
| ackTask | input | TASK_W | Number of the task being acknowledged |
| wakeReq | output | 1 | Wakeup request for the target task |
| wakeTask | output | TASK_W | Task number that the request is for |

## Verification
The bench builds the main instance with `PRE_SHIFT` set to 2. This gives periods of a few edges. Exact first-expiry timing, repeated expiries, an acknowledge that lands on an expiry edge, and a restart in mid-count can then all be checked cycle by cycle.

A second instance uses the default `PRE_SHIFT` of 8. It shows that 400 octal gives the 256-cycle minimum period, and that 377 octal leaves the timer off.

// File: rtl/task_wake_pkg.sv
package task_wake_pkg;
  // Strobes from control to datapath, at most one active per cycle.
  typedef struct packed {
    logic arm;    // accept a non-zero period and restart the count
    logic halt;   // clear the stored period
    logic count;  // advance the prescaler and the unit counter
  } wake_strobe_t;
endpackage

// File: rtl/wake_timer_dp.sv
module wake_timer_dp
  import task_wake_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PRE_SHIFT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  wake_strobe_t               strobe,
  input  logic [DATA_W-PRE_SHIFT-1:0] loadUnits,
  output logic                       enabled,
  output logic                       expire
);
  localparam int UNIT_W = DATA_W - PRE_SHIFT;
  localparam int PRE_W  = (PRE_SHIFT > 0) ? PRE_SHIFT : 1;

  logic [UNIT_W-1:0] reloadQ;
  logic [UNIT_W-1:0] unitQ;
  logic [PRE_W-1:0]  preQ;
  logic              tick;

  generate
    if (PRE_SHIFT == 0) begin : g_noPre
      assign tick = 1'b1;
      always_ff @(posedge clk) preQ <= '0;
    end else begin : g_pre
      assign tick = &preQ;
      always_ff @(posedge clk) begin
        if (!rst_n || strobe.halt || strobe.arm) preQ <= '0;
        else if (strobe.count)                  preQ <= preQ + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.halt) begin
      reloadQ <= '0;
      unitQ   <= '0;
    end else if (strobe.arm) begin
      reloadQ <= loadUnits;
      unitQ   <= loadUnits;
    end else if (strobe.count && tick) begin
      unitQ <= (unitQ == UNIT_W'(1)) ? reloadQ : unitQ - 1'b1;
    end
  end

  assign enabled = (reloadQ != '0);
  assign expire  = strobe.count && tick && (unitQ == UNIT_W'(1));

  // R5: while armed, the unit counter stays within 1..period
  p_unit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reloadQ != '0) |-> (unitQ != '0 && unitQ <= reloadQ));
  // R3: a zero period never produces an expiry
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reloadQ == '0) |-> !expire);
endmodule

// File: rtl/wake_timer_ctrl.sv
module wake_timer_ctrl
  import task_wake_pkg::*;
#(
  parameter int TASK_W      = 4,
  parameter int TARGET_TASK = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic              loadIsZero,
  input  logic              enabled,
  input  logic              expire,
  input  logic              ackValid,
  input  logic [TASK_W-1:0] ackTask,
  output wake_strobe_t      strobe,
  output logic              wakeReq
);
  logic ackHit;

  assign ackHit       = ackValid && (ackTask == TASK_W'(TARGET_TASK));
  assign strobe.arm   = loadEn && !loadIsZero;
  assign strobe.halt  = loadEn && loadIsZero;
  assign strobe.count = !loadEn && enabled;

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.halt) wakeReq <= 1'b0;
    else if (expire)           wakeReq <= 1'b1;
    else if (ackHit)           wakeReq <= 1'b0;
  end

  // R4: a request only appears after an expiry
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wakeReq) |-> $past(expire));
  // R8: a stop write drops the request
  p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.halt |=> !wakeReq);
  // R6: without a matching acknowledge or a stop, the request is held
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeReq && !ackHit && !strobe.halt) |=> wakeReq);
  // R7: an expiry wins over a simultaneous acknowledge
  p_expire_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ackHit) |=> wakeReq);
endmodule

// File: rtl/task_wake_timer.sv
module task_wake_timer
  import task_wake_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PRE_SHIFT   = 8,
  parameter int TASK_W      = 4,
  parameter int TARGET_TASK = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  input  logic              ackValid,
  input  logic [TASK_W-1:0] ackTask,
  output logic              wakeReq,
  output logic [TASK_W-1:0] wakeTask
);
  localparam int UNIT_W = DATA_W - PRE_SHIFT;

  wake_strobe_t      strobe;
  logic [UNIT_W-1:0] loadUnits;
  logic              enabled;
  logic              expire;

  assign loadUnits = loadData[DATA_W-1:PRE_SHIFT];
  assign wakeTask  = TASK_W'(TARGET_TASK);

  wake_timer_ctrl #(.TASK_W(TASK_W), .TARGET_TASK(TARGET_TASK)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn),
    .loadIsZero(loadUnits == '0), .enabled(enabled), .expire(expire),
    .ackValid(ackValid), .ackTask(ackTask), .strobe(strobe), .wakeReq(wakeReq)
  );

  wake_timer_dp #(.DATA_W(DATA_W), .PRE_SHIFT(PRE_SHIFT)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .loadUnits(loadUnits),
    .enabled(enabled), .expire(expire)
  );
endmodule

// File: tb/task_wake_timer_tb_top.sv
module task_wake_timer_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic loadEn;
  logic [15:0] loadData;
  logic ackValid;
  logic [3:0] ackTask;
  logic wakeReq, dfltReq;
  logic [3:0] wakeTask, dfltTask;
  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  task_wake_timer #(.PRE_SHIFT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadData(loadData),
    .ackValid(ackValid), .ackTask(ackTask), .wakeReq(wakeReq), .wakeTask(wakeTask));

  task_wake_timer dutDflt_i (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadData(loadData),
    .ackValid(ackValid), .ackTask(ackTask), .wakeReq(dfltReq), .wakeTask(dfltTask));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doLoad(input logic [15:0] d);
    loadEn = 1'b1; loadData = d;
    @(negedge clk);
    loadEn = 1'b0; loadData = '0;
  endtask

  task automatic doAck(input logic [3:0] t);
    ackValid = 1'b1; ackTask = t;
    @(negedge clk);
    ackValid = 1'b0; ackTask = '0;
  endtask

  task automatic testReset();
    chk("R1 req after reset", wakeReq, 0);
    idle(50);
    chk("R1 req idle", wakeReq, 0);
    chk("R1 default req idle", dfltReq, 0);
    chk("R2 task number", wakeTask, 10);
    chk("R2 default task number", dfltTask, 10);
  endtask

  task automatic testPeriodic();
    doLoad(16'd0);
    doLoad(16'd15);            // period 3, low bits 11 ignored -> 12 edges
    idle(11); chk("R4 before first expiry", wakeReq, 0);
    idle(1);  chk("R4 first expiry", wakeReq, 1);
    doAck(4'd10); chk("R6 ack clears", wakeReq, 0);
    idle(10); chk("R5 before second expiry", wakeReq, 0);
    idle(1);  chk("R5 second expiry", wakeReq, 1);
  endtask

  task automatic testAck();
    doLoad(16'd0);
    doLoad(16'd4);             // period 1 -> 4 edges
    idle(4);  chk("R4 short period", wakeReq, 1);
    doAck(4'd3); chk("R6 other task ignored", wakeReq, 1);
    doAck(4'd10); chk("R6 target ack", wakeReq, 0);
    idle(1);  chk("R5 gap", wakeReq, 0);
    idle(1);  chk("R5 edge 8", wakeReq, 1);
    idle(3);
    doAck(4'd10); chk("R7 expiry beats ack", wakeReq, 1);
  endtask

  task automatic testZeroField();
    doLoad(16'd0);
    doLoad(16'd3);             // period field zero
    idle(40); chk("R3 zero field disables", wakeReq, 0);
  endtask

  task automatic testStop();
    doLoad(16'd4);
    idle(4);  chk("R8 pending before stop", wakeReq, 1);
    doLoad(16'd0); chk("R8 stop clears", wakeReq, 0);
    idle(40); chk("R8 no later wakeup", wakeReq, 0);
  endtask

  task automatic testReload();
    doLoad(16'd20);            // period 5
    idle(10);
    doLoad(16'd8);             // period 2 -> 8 edges from here
    idle(7);  chk("R9 before new expiry", wakeReq, 0);
    idle(1);  chk("R9 new expiry", wakeReq, 1);
    doLoad(16'd0);
  endtask

  task automatic testDefault();
    doLoad(16'd0);
    doLoad(16'o400);
    idle(255); chk("R10 before 256", dfltReq, 0);
    idle(1);   chk("R10 at 256", dfltReq, 1);
    doLoad(16'o377); chk("R10 377 stops", dfltReq, 0);
    idle(300); chk("R10 377 stays off", dfltReq, 0);
  endtask

  initial begin
    rst_n = 1'b0; loadEn = 1'b0; loadData = '0; ackValid = 1'b0; ackTask = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPeriodic();
    testAck();
    testZeroField();
    testStop();
    testReload();
    testDefault();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule